// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Scheduler

This block stands in for one DRAM bank that owns a single row buffer. Requests arrive one at a time over a valid/ready handshake. Each request carries a row, a column, a tag and an arrival time measured in 10 ns ticks. The block serves requests strictly in order. For each request it decides whether the row buffer already holds the row (hit), is precharged (empty) or holds a different row (conflict). It then works out the tick at which the access ends and reports that tick together with the tag, the column and the access class.

A policy input is sampled with every request and chooses how the bank is left after that access. With the open-page choice, the row stays in the buffer. With the close-page choice, the bank precharges straight after the access, and that precharge keeps the bank busy for a further two ticks. Model time comes from a free-running tick counter, and one tick passes per clock. The counter value is visible on a port so that the requester can state arrival times against it.

Top module: `dram_bank_sched`

## Requirements
- R1: After reset the tick counter reads 0, no row is open, `req_ready` is 1 and `done` is 0.
- R2: An access that finds the buffer precharged is classed empty (`done_kind` = 1) and ends 4 ticks after its service start.
- R3: An access to the row already held in the buffer is classed hit (`done_kind` = 0) and ends 2 ticks after its service start.
- R4: An access to a different row while one is held is classed conflict (`done_kind` = 2) and ends 6 ticks after its service start.
- R5: A request accepted with `close_page` = 0 leaves its row open, so the next request to that row is a hit.
- R6: A request accepted with `close_page` = 1 leaves the bank precharged, and the bank stays busy for 2 ticks after that access ends. Later requests wait for this.
- R7: Service starts at the largest of three values: the request's arrival tick, the tick at which the bank becomes free, and the tick at which the request is accepted.
- R8: Only one request is in service at a time. `req_ready` is 0 while a request is in service, except in the cycle in which that request completes, when a new request may be accepted.
- R9: `done` is high for exactly one cycle per request, in the cycle whose tick equals the finish tick. In that cycle `done_tag` and `done_col` carry the request's tag and column.
- R10: The tick counter advances by exactly one every clock cycle, and `done_tick` equals `cur_tick` while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of model time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| close_page | input | 1 | Policy for the request being accepted (1 = close-page) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_arrival | input | TICK_W | Arrival time in ticks |
| req_tag | input | TAG_W | Requester's tag |
| done | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of the completing request |
| done_col | output | COL_W | Column of the completing request |
| done_tick | output | TICK_W | Finish tick of the completing request |
| done_kind | output | 2 | 0 hit, 1 empty, 2 conflict |
| cur_tick | output | TICK_W | Current tick |

## Verification
The hardest case to reach is a request accepted in the very cycle its predecessor completes. The start time of such a request depends on a free time that was just updated, and on the close-page precharge window. The fixed two-row stream with arrivals at ticks 0, 1, 10, 20, 25 and 30 reaches this case under both policies and has known finish ticks. A long seeded random stream then mixes the policy per request, uses a small row set and places arrival times both before and after the bank frees up. This gives hits after closes, conflicts after policy switches, and requests that wait behind a precharge.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic [1:0] {
      KIND_HIT      = 2'd0,
      KIND_EMPTY    = 2'd1,
      KIND_CONFLICT = 2'd2
   } acc_kind_t;
endpackage

// File: rtl/dbs_tick_counter.sv
module dbs_tick_counter #(
   parameter int TICK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TICK_W-1:0] tick
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick <= '0;
      else        tick <= tick + 1'b1;
   end

   // R10
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> tick == $past(tick) + 1'b1);
endmodule

// File: rtl/dbs_row_state.sv
module dbs_row_state
   import dbs_pkg::*;
#(
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic             close,
   input  logic [ROW_W-1:0] row,
   output acc_kind_t        kind
);
   logic             open_v;
   logic [ROW_W-1:0] open_row;

   always_comb begin
      if (!open_v)             kind = KIND_EMPTY;
      else if (open_row == row) kind = KIND_HIT;
      else                     kind = KIND_CONFLICT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_v   <= 1'b0;
         open_row <= '0;
      end else if (upd) begin
         open_v   <= !close;
         if (!close) open_row <= row;
      end
   end

   // R5
   keep_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd && !close |=> open_v && open_row == $past(row));
   // R6
   close_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd && close |=> !open_v);
endmodule

// File: rtl/dbs_timing.sv
module dbs_timing
   import dbs_pkg::*;
#(
   parameter int TICK_W  = 32,
   parameter int HIT_T   = 2,
   parameter int EMPTY_T = 4,
   parameter int CONF_T  = 6
) (
   input  logic [TICK_W-1:0] arrival,
   input  logic [TICK_W-1:0] free_at,
   input  logic [TICK_W-1:0] now,
   input  acc_kind_t         kind,
   input  logic              close,
   output logic [TICK_W-1:0] finish,
   output logic [TICK_W-1:0] free_next
);
   localparam int PRE_T = CONF_T - EMPTY_T;
   localparam logic [TICK_W-1:0] L_HIT   = TICK_W'(HIT_T);
   localparam logic [TICK_W-1:0] L_EMPTY = TICK_W'(EMPTY_T);
   localparam logic [TICK_W-1:0] L_CONF  = TICK_W'(CONF_T);
   localparam logic [TICK_W-1:0] L_PRE   = TICK_W'(PRE_T);

   generate
      if (HIT_T < 1 || HIT_T >= EMPTY_T || EMPTY_T >= CONF_T) begin : g_bad_lat
         initial $fatal(1, "latencies must satisfy 0 < hit < empty < conflict");
      end
   endgenerate

   logic [TICK_W-1:0] t0, start, lat;

   always_comb begin
      t0    = (arrival > free_at) ? arrival : free_at;
      start = (t0 > now) ? t0 : now;
      case (kind)
         KIND_HIT:   lat = L_HIT;
         KIND_EMPTY: lat = L_EMPTY;
         default:    lat = L_CONF;
      endcase
      finish    = start + lat;
      free_next = close ? finish + L_PRE : finish;
   end
endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
   import dbs_pkg::*;
#(
   parameter int TICK_W  = 32,
   parameter int ROW_W   = 8,
   parameter int COL_W   = 6,
   parameter int TAG_W   = 8,
   parameter int HIT_T   = 2,
   parameter int EMPTY_T = 4,
   parameter int CONF_T  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              close_page,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [TICK_W-1:0] req_arrival,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              done,
   output logic [TAG_W-1:0]  done_tag,
   output logic [COL_W-1:0]  done_col,
   output logic [TICK_W-1:0] done_tick,
   output logic [1:0]        done_kind,
   output logic [TICK_W-1:0] cur_tick
);
   generate
      if (TICK_W < 8 || ROW_W < 1 || COL_W < 1 || TAG_W < 1) begin : g_bad_w
         initial $fatal(1, "port widths out of range");
      end
   endgenerate

   logic              busy, accept, finishing;
   logic [TICK_W-1:0] fin_q, free_q, finish, free_next;
   logic [TAG_W-1:0]  tag_q;
   logic [COL_W-1:0]  col_q;
   acc_kind_t         kind, kind_q;

   dbs_tick_counter #(.TICK_W(TICK_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(cur_tick));

   dbs_row_state #(.ROW_W(ROW_W)) u_row (
      .clk(clk), .rst_n(rst_n), .upd(accept), .close(close_page),
      .row(req_row), .kind(kind));

   dbs_timing #(.TICK_W(TICK_W), .HIT_T(HIT_T), .EMPTY_T(EMPTY_T),
                .CONF_T(CONF_T)) u_time (
      .arrival(req_arrival), .free_at(free_q), .now(cur_tick), .kind(kind),
      .close(close_page), .finish(finish), .free_next(free_next));

   assign finishing = busy && (cur_tick == fin_q);
   assign req_ready = !busy || finishing;
   assign accept    = req_valid && req_ready;
   assign done      = finishing;
   assign done_tag  = tag_q;
   assign done_col  = col_q;
   assign done_tick = fin_q;
   assign done_kind = kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         fin_q  <= '0;
         free_q <= '0;
         tag_q  <= '0;
         col_q  <= '0;
         kind_q <= KIND_EMPTY;
      end else if (accept) begin
         busy   <= 1'b1;
         fin_q  <= finish;
         free_q <= free_next;
         tag_q  <= req_tag;
         col_q  <= req_col;
         kind_q <= kind;
      end else if (finishing) begin
         busy   <= 1'b0;
      end
   end

   // R8
   accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   finish_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> done_tick > $past(req_arrival) && done_tick > $past(cur_tick));
   // R10
   done_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> done_tick == cur_tick);
endmodule

// File: tb/tb_dram_bank_sched.sv
`timescale 1ns/1ps
module tb_dram_bank_sched;
   localparam int TICK_W = 32, ROW_W = 8, COL_W = 6, TAG_W = 8;
   localparam int NMAX = 320;

   logic clk = 1'b0, rst_n = 1'b0, close_page = 1'b0, req_valid = 1'b0;
   logic req_ready, done;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic [TICK_W-1:0] req_arrival = '0;
   logic [TAG_W-1:0]  req_tag = '0;
   logic [TAG_W-1:0]  done_tag;
   logic [COL_W-1:0]  done_col;
   logic [TICK_W-1:0] done_tick, cur_tick;
   logic [1:0]        done_kind;

   always #2.5 clk = ~clk;

   dram_bank_sched dut (.*);

   int checks = 0, errors = 0;
   bit pend;
   int exp_tag, exp_col, exp_kind;
   longint exp_fin;
   bit m_open; int m_row; longint m_free;
   int s_row[NMAX]; int s_col[NMAX]; bit s_close[NMAX]; longint s_arr[NMAX];
   bit rel_arr; bit directed; longint lit[6]; int dcount;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_accept(int row, longint arr, bit cl, longint acc, int tag, int col);
      longint st; int lat;
      if (!m_open)         exp_kind = 1;
      else if (m_row == row) exp_kind = 0;
      else                  exp_kind = 2;
      lat = (exp_kind == 0) ? 2 : (exp_kind == 1) ? 4 : 6;
      st = arr;
      if (m_free > st) st = m_free;
      if (acc > st) st = acc;
      exp_fin = st + lat;
      m_free = exp_fin + (cl ? 2 : 0);
      if (cl) m_open = 0; else begin m_open = 1; m_row = row; end
      exp_tag = tag; exp_col = col; pend = 1;
   endtask

   task automatic check_done();
      string kr;
      if (!done) begin
         if (pend && req_ready)
            chk(0, "R8", "ready while in service", 1, 0);
         return;
      end
      if (!pend) begin
         chk(0, "R8", "done with nothing in service", 1, 0);
         return;
      end
      kr = (exp_kind == 0) ? "R3" : (exp_kind == 1) ? "R2" : "R4";
      chk(done_kind == exp_kind, kr, "access class", done_kind, exp_kind);
      chk(done_tick == exp_fin, kr, "finish tick (R7 start rule)", done_tick, exp_fin);
      chk(done_tag == exp_tag, "R9", "tag", done_tag, exp_tag);
      chk(done_col == exp_col, "R9", "column", done_col, exp_col);
      chk(done_tick == cur_tick, "R10", "done tick vs current tick", done_tick, cur_tick);
      if (directed && dcount < 6) begin
         chk(done_tick == lit[dcount], close_page_run ? "R6" : "R5",
             "stream finish tick", done_tick, lit[dcount]);
         dcount++;
      end
      pend = 0;
   endtask

   bit close_page_run;

   task automatic run(int n);
      int i = 0; int guard = 0; int drv = -1;
      while ((i < n || pend) && guard < 20000) begin
         check_done();
         if (i < n) begin
            if (drv != i) begin
               drv = i;
               if (rel_arr) begin
                  longint a = longint'(cur_tick) + s_arr[i];
                  req_arrival = (a < 0) ? '0 : TICK_W'(a);
               end else req_arrival = TICK_W'(s_arr[i]);
               req_row = ROW_W'(s_row[i]); req_col = COL_W'(s_col[i]);
               req_tag = TAG_W'(i); close_page = s_close[i];
            end
            req_valid = 1'b1;
            if (req_ready) begin
               model_accept(s_row[i], longint'(req_arrival), s_close[i],
                            longint'(cur_tick), i % 256, s_col[i]);
               i++;
            end
         end else req_valid = 1'b0;
         @(negedge clk);
         guard++;
      end
      req_valid = 1'b0;
      chk(!pend, "R9", "request never completed", pend, 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_open = 0; m_row = 0; m_free = 0; pend = 0;
      chk(cur_tick == 0, "R1", "tick after reset", cur_tick, 0);
      chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      chk(done == 1'b0, "R1", "done after reset", done, 0);
   endtask

   task automatic load_stream(bit cl);
      longint arr[6] = '{0, 1, 10, 20, 25, 30};
      int rows[6] = '{5, 9, 5, 5, 9, 5};
      for (int k = 0; k < 6; k++) begin
         s_row[k] = rows[k]; s_arr[k] = arr[k]; s_close[k] = cl; s_col[k] = k + 1;
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      // R5: open-page stream
      close_page_run = 0; rel_arr = 0; directed = 1; dcount = 0;
      lit = '{4, 10, 16, 22, 31, 37};
      load_stream(0);
      do_reset();
      run(6);
      // R6: close-page stream
      close_page_run = 1; dcount = 0;
      lit = '{4, 10, 16, 24, 30, 36};
      load_stream(1);
      do_reset();
      run(6);
      // R7 R8: random mix
      directed = 0; rel_arr = 1;
      for (int k = 0; k < 300; k++) begin
         s_row[k] = int'($urandom % 3);
         s_col[k] = int'($urandom % 64);
         s_close[k] = ($urandom % 3) == 0;
         s_arr[k] = longint'($urandom % 12) - 4;
      end
      run(300);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule